// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer

This block sequences the individual time slots of an open-drain single-wire bus. A controller asks for one slot at a time: a write of a one or a zero, a read, a touch (read or write-zero picked by the request bit), or a bus reset with presence detection. The block pulls the line low through an output enable, releases it, samples the line level at a fixed point for the slot types that return data, and ends the slot with a one-cycle done strobe that carries the sampled bit.

All intervals count in a scaled time unit. One unit is `CLKS_PER_US` system clocks multiplied by a runtime scale coefficient. The coefficient is captured when a request is accepted and stretches every interval of that slot by the same factor. Framing of bytes, device addressing and check codes belong to the layers above. The pull-up itself is outside the block, and only the enable that pulls the line low is modelled.

Top module: `owire_slot_timer`

## Requirements
- R1: A write request (`req_kind` = 2'b00) with `req_bit` = 1 drives `bus_oe` high for 6 units and keeps `busy` high for 70 units in total. One unit is `CLKS_PER_US` × effective scale clocks.
- R2: A write request with `req_bit` = 0 drives `bus_oe` high for 60 units, with 70 units of `busy` in total.
- R3: A read request (`req_kind` = 2'b10) drives `bus_oe` high for 6 units, with 70 units of `busy` in total. The result is the `bus_in` level in the last clock cycle of the 9 units that follow the release.
- R4: A reset request (`req_kind` = 2'b11) drives `bus_oe` high for 500 units. It samples `bus_in` in the last clock of the 70 units after release and keeps `busy` high for 1000 units in total. A result of 0 means a device answered, and 1 means none did.
- R5: A touch request (`req_kind` = 2'b01) with `req_bit` = 1 behaves as a read slot and returns the sampled bit. With `req_bit` = 0 it behaves as a write-zero slot and returns 0.
- R6: `scale` is captured at acceptance, and a value of 0 counts as 1. Changing `scale` during a slot does not affect that slot.
- R7: A request is accepted only at an edge where `busy` is low. `busy` rises in the cycle after acceptance. A request presented while `busy` is high is ignored and does not start a later slot.
- R8: `done` is high for exactly one cycle, the first cycle with `busy` low after a slot. `result` is valid with it and keeps its value until the next slot ends. Write slots return 0.
- R9: `bus_oe` is high only during the low phase of a slot and never while `busy` is low.
- R10: A synchronous active-high `rst` returns the block to idle with `busy`, `done`, `result` and `bus_oe` low, even in the middle of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scale | input | SCALE_W | Interval stretch coefficient, 0 treated as 1 |
| req_valid | input | 1 | Slot request, taken when idle |
| req_kind | input | 2 | 00 write, 01 touch, 10 read, 11 reset |
| req_bit | input | 1 | Data bit for write and touch requests |
| busy | output | 1 | High from the cycle after acceptance until the slot ends |
| done | output | 1 | One-cycle end-of-slot strobe |
| result | output | 1 | Sampled bit or presence result |
| bus_oe | output | 1 | High pulls the bus line low |
| bus_in | input | 1 | Sampled bus line level |

## Verification
The sampling point is probed from both sides. A modelled device holds the line low for exactly the release window, or for one clock less. A timer that samples a cycle early or late would return the wrong bit for one of the two cases, in both the read and the reset slots. The scale is checked at zero, at a non-unit value, and with a change in mid-slot. A design that multiplied only some intervals, or read the live coefficient, would show wrong low-phase or busy lengths. Requests presented during a slot, and a reset during a slot, catch a design that queues or restarts work it should drop.

// File: rtl/owire_pkg.sv
package owire_pkg;

  localparam int US_W = 10;

  localparam logic [1:0] KIND_WRITE = 2'b00;
  localparam logic [1:0] KIND_TOUCH = 2'b01;
  localparam logic [1:0] KIND_READ  = 2'b10;
  localparam logic [1:0] KIND_RESET = 2'b11;

  typedef enum logic [1:0] {SLOT_W0, SLOT_W1, SLOT_RD, SLOT_RST} slot_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_REL, ST_TAIL} state_e;

  function automatic slot_e decode_req(input logic [1:0] kind, input logic b);
    case (kind)
      KIND_WRITE: return b ? SLOT_W1 : SLOT_W0;
      KIND_TOUCH: return b ? SLOT_RD : SLOT_W0;
      KIND_READ:  return SLOT_RD;
      default:    return SLOT_RST;
    endcase
  endfunction

  function automatic logic [US_W-1:0] low_us(input slot_e s);
    case (s)
      SLOT_W0: return US_W'(60);
      SLOT_W1: return US_W'(6);
      SLOT_RD: return US_W'(6);
      default: return US_W'(500);
    endcase
  endfunction

  function automatic logic [US_W-1:0] rel_us(input slot_e s);
    case (s)
      SLOT_W0: return US_W'(10);
      SLOT_W1: return US_W'(64);
      SLOT_RD: return US_W'(9);
      default: return US_W'(70);
    endcase
  endfunction

  function automatic logic [US_W-1:0] tail_us(input slot_e s);
    case (s)
      SLOT_RD:  return US_W'(55);
      SLOT_RST: return US_W'(430);
      default:  return US_W'(0);
    endcase
  endfunction

  function automatic logic has_sample(input slot_e s);
    return (s == SLOT_RD) || (s == SLOT_RST);
  endfunction

endpackage

// File: rtl/owire_us_tick.sv
module owire_us_tick #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] last;

  assign last = PW'(period - PW'(1));
  assign tick = (pre_q == last);

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else if (tick)      pre_q <= '0;
    else                pre_q <= PW'(pre_q + PW'(1));
  end

  // R6
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    (period != '0) |-> (pre_q < period));

endmodule

// File: rtl/owire_phase_cnt.sv
module owire_phase_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] rem_q;

  assign expire = tick && (rem_q == W'(1));

  always_ff @(posedge clk) begin
    if (rst)                         rem_q <= '0;
    else if (load)                   rem_q <= load_val;
    else if (tick && rem_q != '0)    rem_q <= W'(rem_q - W'(1));
  end

  // R7
  rem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rem_q == '0 && !load) |=> (rem_q == '0));

endmodule

// File: rtl/owire_slot_timer.sv
module owire_slot_timer
  import owire_pkg::*;
#(
  parameter int CLKS_PER_US = 48,
  parameter int SCALE_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SCALE_W-1:0] scale,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic               req_bit,
  output logic               busy,
  output logic               done,
  output logic               result,
  output logic               bus_oe,
  input  logic               bus_in
);
  localparam int PW = $clog2(CLKS_PER_US + 1) + SCALE_W;

  function automatic logic [PW-1:0] unit_clocks(input logic [SCALE_W-1:0] s);
    logic [SCALE_W-1:0] eff;
    eff = (s == '0) ? SCALE_W'(1) : s;
    return PW'(PW'(CLKS_PER_US) * PW'(eff));
  endfunction

  state_e          state_q;
  slot_e           slot_q;
  slot_e           slot_d;
  logic [PW-1:0]   period_q;
  logic            sample_q;
  logic            done_q;
  logic            result_q;

  logic            tick;
  logic            expire;
  logic            phase_end;
  logic            accept;
  logic            sample_evt;
  logic            finish;
  logic            line_bit;
  logic            load;
  logic [US_W-1:0] load_val;

  assign slot_d     = decode_req(req_kind, req_bit);
  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign phase_end  = expire && (state_q != ST_IDLE);
  assign sample_evt = phase_end && (state_q == ST_REL) && has_sample(slot_q);
  assign finish     = phase_end && ((state_q == ST_TAIL) ||
                      ((state_q == ST_REL) && (tail_us(slot_q) == '0)));
  assign line_bit   = has_sample(slot_q) ? bus_in : 1'b0;

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    if (accept) begin
      load     = 1'b1;
      load_val = low_us(slot_d);
    end else if (phase_end && state_q == ST_LOW) begin
      load     = 1'b1;
      load_val = rel_us(slot_q);
    end else if (phase_end && state_q == ST_REL && !finish) begin
      load     = 1'b1;
      load_val = tail_us(slot_q);
    end
  end

  owire_us_tick #(.PW(PW)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .period  (period_q),
    .tick    (tick)
  );

  owire_phase_cnt #(.W(US_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .tick     (tick),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      slot_q   <= SLOT_W0;
      period_q <= '0;
      sample_q <= 1'b0;
      done_q   <= 1'b0;
      result_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_LOW;
          slot_q   <= slot_d;
          period_q <= unit_clocks(scale);
        end
        ST_LOW: if (phase_end) state_q <= ST_REL;
        ST_REL: if (phase_end) begin
          sample_q <= line_bit;
          if (finish) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            result_q <= line_bit;
          end else begin
            state_q <= ST_TAIL;
          end
        end
        default: if (phase_end) begin
          state_q  <= ST_IDLE;
          done_q   <= 1'b1;
          result_q <= sample_q;
        end
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign bus_oe = (state_q == ST_LOW);
  assign done   = done_q;
  assign result = result_q;

  // R9
  oe_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> busy);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8
  write_result_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !has_sample(slot_q)) |-> !result);

  // R6
  slot_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> ($stable(slot_q) && $stable(period_q)));

  // R3
  sample_in_release_chk: assert property (@(posedge clk) disable iff (rst)
    sample_evt |-> (!bus_oe && busy));

endmodule

// File: tb/owire_slot_timer_test.sv
module owire_slot_timer_test;
  import owire_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] scale = 4'd1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic       req_bit = 1'b0;
  logic       busy, done, result, bus_oe, bus_in;

  logic       dev_en = 1'b0;
  int         dev_hold = 0;
  int         rel_cnt;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    int    low;
    int    total;
    logic  res;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  owire_slot_timer #(.CLKS_PER_US(CPU), .SCALE_W(4)) uut (
    .clk(clk), .rst(rst), .scale(scale), .req_valid(req_valid),
    .req_kind(req_kind), .req_bit(req_bit), .busy(busy), .done(done),
    .result(result), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  // device model: holds the line low for dev_hold clocks after each release
  always_ff @(posedge clk) begin
    if (bus_oe)              rel_cnt <= 0;
    else if (rel_cnt < 60000) rel_cnt <= rel_cnt + 1;
  end
  assign bus_in = !bus_oe && !(dev_en && rel_cnt < dev_hold);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  int bcnt = 0;
  int ocnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        bcnt = 0; ocnt = 0;
      end else begin
        if (busy) begin
          bcnt++;
          if (bus_oe) ocnt++;
        end else if (bus_oe) begin
          check(0, "R9 oe while idle", 1, 0);
        end
        if (done) begin
          if (exp_q.size() == 0) begin
            check(0, "R7 unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(ocnt == e.low, {e.tag, "/R9 low phase"}, ocnt, e.low);
            check(bcnt == e.total, {e.tag, " busy length"}, bcnt, e.total);
            check(result == e.res, {e.tag, " result"}, int'(result), int'(e.res));
            check(!busy, "R8 done with busy low", int'(busy), 0);
          end
          bcnt = 0; ocnt = 0;
        end
      end
    end
  end

  // driver: poke 1 changes scale mid-slot, poke 2 presents a request mid-slot
  task automatic do_slot(input logic [1:0] kind, input logic b, input logic [3:0] sc,
                         input bit den, input int dh, input int el, input int et,
                         input logic er, input string tag, input int poke);
    exp_t e;
    while (busy) @(negedge clk);
    dev_en = den; dev_hold = dh;
    e.low = el; e.total = et; e.res = er; e.tag = tag;
    exp_q.push_back(e);
    req_kind = kind; req_bit = b; scale = sc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    if (poke == 1) scale = 4'd5;
    if (poke == 2) begin
      req_kind = KIND_RESET; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!busy && !done && !result && !bus_oe, "R10 reset state",
          int'({busy, done, result, bus_oe}), 0);

    // R1 write-one: 6 and 70 units of 2 clocks
    do_slot(KIND_WRITE, 1'b1, 4'd1, 1'b0, 0, 12, 140, 1'b0, "R1", 0);
    // R2 write-zero
    do_slot(KIND_WRITE, 1'b0, 4'd1, 1'b0, 0, 120, 140, 1'b0, "R2", 0);
    // R3 read, device low through the sample cycle and one clock short
    do_slot(KIND_READ, 1'b0, 4'd1, 1'b1, 18, 12, 140, 1'b0, "R3 hold", 0);
    do_slot(KIND_READ, 1'b0, 4'd1, 1'b1, 17, 12, 140, 1'b1, "R3 short", 0);
    // R5 touch
    do_slot(KIND_TOUCH, 1'b1, 4'd1, 1'b1, 18, 12, 140, 1'b0, "R5 touch1 low", 0);
    do_slot(KIND_TOUCH, 1'b1, 4'd1, 1'b0, 0, 12, 140, 1'b1, "R5 touch1 high", 0);
    do_slot(KIND_TOUCH, 1'b0, 4'd1, 1'b0, 0, 120, 140, 1'b0, "R5 touch0", 0);
    // R4 reset with presence / absence
    do_slot(KIND_RESET, 1'b0, 4'd1, 1'b1, 140, 1000, 2000, 1'b0, "R4 present", 0);
    do_slot(KIND_RESET, 1'b0, 4'd1, 1'b1, 139, 1000, 2000, 1'b1, "R4 short", 0);
    do_slot(KIND_RESET, 1'b0, 4'd1, 1'b0, 0, 1000, 2000, 1'b1, "R4 absent", 0);
    // R6 scale
    do_slot(KIND_WRITE, 1'b1, 4'd3, 1'b0, 0, 36, 420, 1'b0, "R6 scale3", 0);
    do_slot(KIND_WRITE, 1'b0, 4'd0, 1'b0, 0, 120, 140, 1'b0, "R6 scale0", 0);
    do_slot(KIND_READ, 1'b0, 4'd2, 1'b1, 36, 24, 280, 1'b0, "R6 midchange", 1);
    // R7 request during a slot is dropped
    do_slot(KIND_WRITE, 1'b0, 4'd1, 1'b0, 0, 120, 140, 1'b0, "R7 ignored", 2);
    for (int i = 0; i < 3; i++) begin
      check(!busy, "R7 no late slot", int'(busy), 0);
      @(negedge clk);
    end

    // R10 reset in mid-slot
    dev_en = 1'b0;
    req_kind = KIND_RESET; scale = 4'd1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(busy && bus_oe, "R10 slot running", int'({busy, bus_oe}), 3);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !bus_oe && !done && !result, "R10 mid-slot reset",
          int'({busy, bus_oe, done, result}), 0);
    repeat (2500) begin
      @(negedge clk);
      if (busy || done) begin
        check(0, "R10 activity after reset", 1, 0);
        break;
      end
    end
    check(exp_q.size() == 0, "R8 all slots completed", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule